// File: doc/BRIEF.md
# Locality-Register Read Cache

This block is a direct-mapped, read-only cache controller that sits between a requester and a slower line memory. Each line keeps only a few low bits of its address tag. The remaining high tag bits are not stored per line. They are held once, in a single shared locality register that names the address region the program is currently working in.

Every request first compares its high tag bits against the locality register. If they agree, the short per-line tag decides hit or miss in the usual way, and a miss fills the line. If they disagree, the request is fetched from memory and returned, and the cache line is left alone. A run of out-of-region requests that all point at the same region moves the locality register to that region. When that happens, every valid bit is dropped at once, so an old line with matching short tag bits cannot answer for the new region.

Only one memory fetch is in flight at a time. The requester is held off until the fetch completes.

Top module: `locality_tag_cache`

## Requirements
- R1: During and after reset, the block accepts requests (`cpu_req_ready`=1), shows no response and makes no memory request.
- R2: With the default parameters, a 32-bit request address splits into these fields: offset bits [2:0], line index bits [12:3] (1024 lines of 8 bytes), stored short tag bits [16:13] (4 bits), and locality bits [31:17].
- R3: A request whose locality bits match the register, whose line is valid and whose short tag matches is answered in the cycle after acceptance. The answer has `cpu_resp_hit`=1, the stored line data and no memory request.
- R4: A short-tag miss inside the current locality raises a memory request for the line-aligned address (offset bits zero) in the cycle after acceptance. It answers with `cpu_resp_hit`=0 and the memory data in the cycle after `mem_resp_valid`, and it fills the line, so a repeat of the request hits.
- R5: Two addresses in the current locality with the same index but different short tags evict each other, and neither is ever reported as a hit for the other.
- R6: A request whose locality bits differ from the register is served from memory with `cpu_resp_hit`=0 and does not replace the line at its index. A line cached earlier at that index still hits afterwards.
- R7: The third consecutive locality mismatch (parameter `RELOAD_MISSES`=3) carrying the same locality bits loads those bits into the register. In the same cycle it invalidates every line, so a line cached under the old region with equal index and short tag then misses.
- R8: A locality match, or a mismatch with different locality bits, restarts the mismatch count. Such a broken run does not move the register.
- R9: Once a miss is accepted, `cpu_req_ready` stays low until the response cycle. Meanwhile `mem_req_valid` stays high with a stable address until `mem_resp_valid` is seen.
- R10: After reset the locality register holds no region. The first request is treated as a mismatch: it is served from memory without filling, and it loads its locality bits into the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_valid | input | 1 | Request strobe from the requester |
| cpu_req_addr | input | 32 | Byte address of the request |
| cpu_req_ready | output | 1 | High when a request can be taken |
| cpu_resp_valid | output | 1 | One-cycle response strobe |
| cpu_resp_hit | output | 1 | Response came from the cache |
| cpu_resp_data | output | 64 | Full line holding the requested address |
| mem_req_valid | output | 1 | Line fetch pending, held until the response |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_resp_valid | input | 1 | One-cycle fetch completion strobe |
| mem_resp_data | input | 64 | Fetched line |

## Verification
A hit passes through one output register, so its response is due at the first falling edge after the accepting rising edge. The bench requires it there and requires that no memory request is visible at that edge. A miss shows its memory request at the first falling edge after acceptance. Its response is due one edge after the bench's memory model drives `mem_resp_valid`. The bench samples every falling edge in between and requires `cpu_req_ready` low and the request address correct at each of them. All inputs change on falling edges and all outputs are read there, so the expected value always belongs to a known edge.

// File: rtl/ltc_pkg.sv
// Package: shared types for the locality-register read cache.
// Assumes: imported by the top module only.
package ltc_pkg;

    // Controller state: idle/lookup, or waiting for one line fetch
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ltc_state_e;

endpackage

// File: rtl/ltc_locality.sv
// Module: shared locality register plus mismatch-run tracker.
// Compares the high tag bits of an accepted request against the register.
// On a mismatch it counts consecutive mismatches that carry identical high bits.
// It raises reload, together with the access, when the register must take the new bits.
// Assumes: access is a single-cycle strobe per accepted request.
module ltc_locality #(
    parameter int UP_W          = 15,
    parameter int RELOAD_MISSES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            access,
    input  logic [UP_W-1:0] up_tag,
    output logic            loc_match,
    output logic            reload
);
    localparam int CNT_W = $clog2(RELOAD_MISSES + 1);

    logic             loc_valid;
    logic [UP_W-1:0]  loc_tag;
    logic             cand_valid;
    logic [UP_W-1:0]  cand_tag;
    logic [CNT_W-1:0] cand_cnt;
    logic             same_cand;
    logic [CNT_W-1:0] next_cnt;

    // Locality hit and the length the mismatch run would reach
    always_comb begin
        loc_match = loc_valid && (up_tag == loc_tag);
        same_cand = cand_valid && (up_tag == cand_tag);
        next_cnt  = same_cand ? cand_cnt + 1'b1 : CNT_W'(1);
        reload    = access && !loc_match &&
                    (!loc_valid || next_cnt >= CNT_W'(RELOAD_MISSES));
    end

    // Register update: load on reload, else track or break the run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_valid  <= 1'b0;
            loc_tag    <= '0;
            cand_valid <= 1'b0;
            cand_tag   <= '0;
            cand_cnt   <= '0;
        end else if (access) begin
            if (reload) begin
                loc_valid  <= 1'b1;
                loc_tag    <= up_tag;
                cand_valid <= 1'b0;
                cand_cnt   <= '0;
            end else if (loc_match) begin
                cand_valid <= 1'b0;
                cand_cnt   <= '0;
            end else begin
                cand_valid <= 1'b1;
                cand_tag   <= up_tag;
                cand_cnt   <= next_cnt;
            end
        end
    end

endmodule

// File: rtl/ltc_tag_store.sv
// Module: per-line valid bits and short tags.
// Reads are combinational at rd_idx. A fill writes one entry.
// clear_all drops every valid bit in one cycle.
// Assumes: clear_all and wr_en are never high together (the controller guarantees it).
module ltc_tag_store #(
    parameter int LINES  = 1024,
    parameter int RTAG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic                     rd_valid,
    output logic [RTAG_W-1:0]        rd_tag,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [RTAG_W-1:0]        wr_tag,
    input  logic                     clear_all
);
    logic [LINES-1:0]  valid_q;
    logic [RTAG_W-1:0] tag_mem [LINES];

    // Combinational lookup of the addressed entry
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_mem[rd_idx];
    end

    // Valid vector: reset, bulk clear, or set on fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clear_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Short tag array: written on fill only
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

endmodule

// File: rtl/ltc_data_store.sv
// Module: line data array, one write port and one combinational read port.
// Assumes: contents matter only where the tag store marks a line valid.
module ltc_data_store #(
    parameter int LINES  = 1024,
    parameter int LINE_W = 64
) (
    input  logic                     clk,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic [LINE_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [LINE_W-1:0]        wr_data
);
    logic [LINE_W-1:0] data_mem [LINES];

    // Combinational read of the addressed line
    always_comb rd_data = data_mem[rd_idx];

    // Fill write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/locality_tag_cache.sv
// Module: top of the direct-mapped read cache with a shared locality register.
// Lookup happens in the accepting cycle; hits answer one cycle later.
// Misses wait in ST_FETCH for one memory response. The fill is written only when
// the request matched the locality register at acceptance time.
// Assumes: the memory returns exactly one mem_resp_valid pulse per request.
module locality_tag_cache
    import ltc_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int LINE_BYTES    = 8,
    parameter int LINES         = 1024,
    parameter int RTAG_W        = 4,
    parameter int RELOAD_MISSES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req_valid,
    input  logic [ADDR_W-1:0]       cpu_req_addr,
    output logic                    cpu_req_ready,
    output logic                    cpu_resp_valid,
    output logic                    cpu_resp_hit,
    output logic [LINE_BYTES*8-1:0] cpu_resp_data,
    output logic                    mem_req_valid,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_resp_valid,
    input  logic [LINE_BYTES*8-1:0] mem_resp_data
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int UP_W   = TAG_W - RTAG_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int LA_W   = ADDR_W - OFF_W;

    ltc_state_e        state_q;
    logic [LA_W-1:0]   line_q;
    logic              alloc_q;

    logic              accept;
    logic [IDX_W-1:0]  req_idx;
    logic [RTAG_W-1:0] req_rtag;
    logic [UP_W-1:0]   req_up;
    logic              loc_match;
    logic              loc_reload;
    logic              rd_valid;
    logic [RTAG_W-1:0] rd_tag;
    logic [LINE_W-1:0] rd_data;
    logic              tag_hit;
    logic              fill_en;
    logic              unused_offset_bits;

    // Address field split and handshake decode
    always_comb begin
        req_idx            = cpu_req_addr[OFF_W +: IDX_W];
        req_rtag           = cpu_req_addr[OFF_W+IDX_W +: RTAG_W];
        req_up             = cpu_req_addr[ADDR_W-1 -: UP_W];
        unused_offset_bits = ^cpu_req_addr[OFF_W-1:0];
        cpu_req_ready      = (state_q == ST_IDLE);
        accept             = cpu_req_valid && cpu_req_ready;
        tag_hit            = loc_match && rd_valid && (rd_tag == req_rtag);
        fill_en            = (state_q == ST_FETCH) && mem_resp_valid && alloc_q;
        mem_req_valid      = (state_q == ST_FETCH);
        mem_req_addr       = {line_q, {OFF_W{1'b0}}};
    end

    ltc_locality #(
        .UP_W          (UP_W),
        .RELOAD_MISSES (RELOAD_MISSES)
    ) locality_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .access    (accept),
        .up_tag    (req_up),
        .loc_match (loc_match),
        .reload    (loc_reload)
    );

    ltc_tag_store #(
        .LINES  (LINES),
        .RTAG_W (RTAG_W)
    ) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (req_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .wr_en     (fill_en),
        .wr_idx    (line_q[IDX_W-1:0]),
        .wr_tag    (line_q[IDX_W +: RTAG_W]),
        .clear_all (loc_reload)
    );

    ltc_data_store #(
        .LINES  (LINES),
        .LINE_W (LINE_W)
    ) data_i (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_data (rd_data),
        .wr_en   (fill_en),
        .wr_idx  (line_q[IDX_W-1:0]),
        .wr_data (mem_resp_data)
    );

    // Controller: answer hits, launch and finish one fetch per miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            line_q         <= '0;
            alloc_q        <= 1'b0;
            cpu_resp_valid <= 1'b0;
            cpu_resp_hit   <= 1'b0;
            cpu_resp_data  <= '0;
        end else begin
            cpu_resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (tag_hit) begin
                            cpu_resp_valid <= 1'b1;
                            cpu_resp_hit   <= 1'b1;
                            cpu_resp_data  <= rd_data;
                        end else begin
                            state_q <= ST_FETCH;
                            line_q  <= cpu_req_addr[ADDR_W-1:OFF_W];
                            alloc_q <= loc_match;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_resp_valid) begin
                        cpu_resp_valid <= 1'b1;
                        cpu_resp_hit   <= 1'b0;
                        cpu_resp_data  <= mem_resp_data;
                        state_q        <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ltc_checker.sv
// Module: protocol and ordering assertions for locality_tag_cache.
// Attached by the bind below. It observes the ports plus the locality compare
// and reload strobes.
module ltc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 3,
    parameter int LINE_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              cpu_resp_hit,
    input logic [LINE_W-1:0] cpu_resp_data,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_resp_valid,
    input logic [LINE_W-1:0] mem_resp_data,
    input logic              loc_match,
    input logic              loc_reload
);

    // A pending fetch keeps the requester waiting (R9)
    assert_fetch_blocks_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    // An unanswered fetch stays up with the same address (R9)
    assert_fetch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // Fetch addresses are whole lines (R4)
    assert_line_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

    // The memory response is forwarded one cycle later as a miss (R4)
    assert_fill_answers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_resp_valid) |=>
            (cpu_resp_valid && !cpu_resp_hit && cpu_resp_data == $past(mem_resp_data)));

    // An accepted request outside the locality always goes to memory (R6)
    assert_outside_goes_to_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && !loc_match) |=> mem_req_valid);

    // A hit answer follows an accepted request directly (R3)
    assert_hit_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_resp_valid && cpu_resp_hit) |-> $past(cpu_req_valid && cpu_req_ready));

    // The register only moves on an accepted mismatch (R7)
    assert_reload_on_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_reload |-> (cpu_req_valid && cpu_req_ready && !loc_match));

endmodule

bind locality_tag_cache ltc_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .LINE_W (LINE_W)
) checker_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .cpu_resp_hit   (cpu_resp_hit),
    .cpu_resp_data  (cpu_resp_data),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .loc_match      (loc_match),
    .loc_reload     (loc_reload)
);

// File: tb/locality_tag_cache_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic.
// A bench-side requirement model predicts each hit or miss.
module locality_tag_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic        cpu_req_ready;
    logic        cpu_resp_valid;
    logic        cpu_resp_hit;
    logic [63:0] cpu_resp_data;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [63:0] mem_resp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int mem_wait = 0;

    // Requirement model state (R2 field layout, R7 threshold of 3)
    bit          m_loc_valid;
    logic [14:0] m_loc;
    bit          m_cand_valid;
    logic [14:0] m_cand;
    int          m_cnt;
    bit          m_valid [1024];
    logic [18:0] m_tag   [1024];

    always #2 clk = ~clk;   // 250 MHz

    locality_tag_cache dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_hit   (cpu_resp_hit),
        .cpu_resp_data  (cpu_resp_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data)
    );

    function automatic logic [63:0] line_data(input logic [31:0] a);
        return {a[31:3] ^ 29'h0A5C3E1, 3'b101, ~a[31:3], 3'b010};
    endfunction

    // R2: {locality[31:17], short tag[16:13], index[12:3], offset[2:0]}
    function automatic logic [31:0] mk(input logic [14:0] up, input logic [3:0] lo,
                                       input logic [9:0] idx, input logic [2:0] off);
        return {up, lo, idx, off};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Memory model: answers each fetch after a short address-dependent delay
    always @(negedge clk) begin
        mem_resp_valid = 1'b0;
        if (rst_n && mem_req_valid) begin
            if (mem_wait >= int'(mem_req_addr[4:3])) begin
                mem_resp_valid = 1'b1;
                mem_resp_data  = line_data(mem_req_addr);
                mem_wait       = 0;
            end else begin
                mem_wait++;
            end
        end
    end

    // Model step: returns the expected hit flag and updates the model
    task automatic model_step(input logic [31:0] a, output bit hit);
        logic [14:0] up;
        logic [9:0]  idx;
        int          nc;
        up  = a[31:17];
        idx = a[12:3];
        hit = 1'b0;
        if (m_loc_valid && up == m_loc) begin
            m_cand_valid = 1'b0;
            m_cnt        = 0;
            hit          = m_valid[idx] && (m_tag[idx] == a[31:13]);
            if (!hit) begin
                m_valid[idx] = 1'b1;
                m_tag[idx]   = a[31:13];
            end
        end else begin
            nc = (m_cand_valid && up == m_cand) ? m_cnt + 1 : 1;
            if (!m_loc_valid || nc >= 3) begin
                m_loc_valid  = 1'b1;
                m_loc        = up;
                m_cand_valid = 1'b0;
                m_cnt        = 0;
                foreach (m_valid[i]) m_valid[i] = 1'b0;
            end else begin
                m_cand_valid = 1'b1;
                m_cand       = up;
                m_cnt        = nc;
            end
        end
    endtask

    // One request: drive, wait for the answer, compare with the model
    task automatic access(input logic [31:0] a, input string req);
        bit exp_hit;
        bit saw_req;
        bit addr_ok;
        bit stall_ok;
        int waited;
        model_step(a, exp_hit);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        saw_req  = 1'b0;
        addr_ok  = 1'b1;
        stall_ok = 1'b1;
        waited   = 0;
        while (!cpu_resp_valid && waited < 100) begin
            if (mem_req_valid) begin
                saw_req = 1'b1;
                if (mem_req_addr !== {a[31:3], 3'b000}) addr_ok = 1'b0;
            end
            if (cpu_req_ready) stall_ok = 1'b0;
            @(negedge clk);
            waited++;
        end
        check(req, "response arrived", 64'(cpu_resp_valid), 64'd1);
        check(req, "hit flag", 64'(cpu_resp_hit), 64'(exp_hit));
        check(req, "line data", cpu_resp_data, line_data(a));
        if (exp_hit) begin
            check("R3", "hit latency in cycles", 64'(waited), 64'd0);
            check("R3", "no fetch on hit", 64'(mem_req_valid), 64'd0);
        end else begin
            check("R4", "fetch issued", 64'(saw_req), 64'd1);
            check("R4", "fetch line address", 64'(addr_ok), 64'd1);
            check("R9", "requester stalled", 64'(stall_ok), 64'd1);
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

    localparam logic [14:0] U0 = 15'h0012;
    localparam logic [14:0] U1 = 15'h0345;
    localparam logic [14:0] U2 = 15'h1a01;

    initial begin
        logic [31:0] a_addr;
        logic [31:0] b_addr;
        logic [31:0] c_addr;
        logic [31:0] d_addr;
        logic [31:0] e_addr;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1: outputs while reset is held
        check("R1", "ready in reset", 64'(cpu_req_ready), 64'd1);
        check("R1", "no response in reset", 64'(cpu_resp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", 64'(cpu_req_ready), 64'd1);
        check("R1", "no response after reset", 64'(cpu_resp_valid), 64'd0);
        check("R1", "no fetch after reset", 64'(mem_req_valid), 64'd0);

        a_addr = mk(U0, 4'h1, 10'd5, 3'd4);   // R2 field layout
        b_addr = mk(U0, 4'h2, 10'd5, 3'd0);
        c_addr = mk(U1, 4'h7, 10'd5, 3'd2);
        d_addr = mk(U2, 4'h1, 10'd9, 3'd0);
        e_addr = mk(U1, 4'h1, 10'd5, 3'd6);

        access(a_addr, "R10 first access misses and loads locality");
        access(a_addr, "R10 no fill on first access, R4 fill now");
        access(a_addr, "R3 hit after fill");
        access(b_addr, "R5 conflicting short tag misses");
        access(a_addr, "R5 evicted line misses");
        access(a_addr, "R3 hit again");
        access(c_addr, "R6 outside locality served from memory");
        access(a_addr, "R6 line kept after outside access");
        access(c_addr, "R8 run count 1");
        access(c_addr, "R8 run count 2");
        access(d_addr, "R8 different locality restarts run");
        access(c_addr, "R8 run count 1 again");
        access(c_addr, "R8 run count 2 again");
        access(a_addr, "R8 match breaks run, still hits");
        access(c_addr, "R7 run 1");
        access(c_addr, "R7 run 2");
        access(c_addr, "R7 run 3 reloads");
        access(e_addr, "R7 stale line with same short tag must miss");
        access(e_addr, "R7 new locality fills and hits");
        access(a_addr, "R7 old locality now outside");

        for (int n = 0; n < 400; n++) begin
            logic [14:0] up;
            int          sel;
            sel = int'($urandom % 5);
            up  = (sel < 3) ? U0 : ((sel == 3) ? U1 : U2);
            access(mk(up, 4'($urandom % 3), 10'(5 + $urandom % 4), 3'($urandom)),
                   "R3 R4 R6 R7 random mix");
        end
        finish_run();
    end

endmodule